// File: doc/BRIEF.md
# Serial SAR Converter Sequencer

This block is the digital half of an eight-input, 12-bit successive-approximation converter. It is clocked entirely by the serial clock `sclk` and held in reset while the active-low select `cs_n` is high. With select low, a control byte arrives serially on `din`. The byte chooses the input channel, single-ended or pseudo-differential input, and unipolar or bipolar coding. The block opens the track/hold window at fixed points inside that byte.

After the hold point, the block raises a one-period strobe. It then runs twelve trial-and-decide steps against a digital comparator input, `cmp_hi`. The trial word goes out on `dac_code` toward the capacitive DAC. Each decided bit is shifted out on `dout` as it is decided, MSB first. Tri-state control of the serial outputs is given as enable signals for the pad ring.

Top module: `sar_adc_serial`

## Requirements
- R1: `din` is sampled on rising `sclk` edges. The first 1 seen with `cs_n` low is the start bit, and any zeros before it are ignored. The next seven bits, in arrival order, are SGL (1 = single-ended), channel code C2, C1, C0, UNI (1 = unipolar), and two don't-care bits.
- R2: While `cs_n` is high, `dout_oe`, `sstrb_oe`, `track`, `sstrb` and `dac_code` are all 0, and bits on `din` are not counted. Raising `cs_n` in mid-frame cancels the frame.
- R3: `track` rises on the falling edge after the 5th control bit (start bit = bit 1). It falls on the falling edge after the 8th bit, so it stays high for three `sclk` periods.
- R4: `sstrb` goes high on the falling edge after the 8th bit and is high for exactly one `sclk` period.
- R5: At the falling edge where `track` rises, `ch_pos` takes the channel code. `neg_gnd` takes SGL. When `neg_gnd` is 0, `ch_neg` is the channel code with its LSB inverted (pairs 0/1, 2/3, 4/5, 6/7). `ch_pos` stays stable while `track` is high.
- R6: At the hold edge, `bipolar` takes the inverse of UNI.
- R7: At the hold edge, `dac_code` becomes 0x800. On each of the next twelve falling edges, the bit under test is kept if `cmp_hi` is 1 and cleared if it is 0, and the next lower bit is set. The final word holds the result, and full scale gives 0xFFF.
- R8: On each decision edge, `dout` takes the bit just decided, so the result leaves MSB first. At all other times `dout` is 0.
- R9: A new start bit is accepted from the first rising edge after the LSB decision. With `din` held high, a new conversion starts every 20 `sclk` periods, and 1s arriving during a conversion do not restart it.
- R10: `dout` is 0 during the strobe period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; sole timing source |
| cs_n | input | 1 | Active-low select; high acts as reset |
| din | input | 1 | Serial control input |
| cmp_hi | input | 1 | Comparator: 1 when input is at or above the DAC level |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Output enable for `dout` |
| sstrb | output | 1 | Conversion-start strobe |
| sstrb_oe | output | 1 | Output enable for `sstrb` |
| track | output | 1 | 1 = track/hold tracking, 0 = holding |
| ch_pos | output | 3 | Positive input channel select |
| ch_neg | output | 3 | Negative input channel select (differential) |
| neg_gnd | output | 1 | 1 = negative input tied to ground |
| bipolar | output | 1 | 1 = bipolar coding |
| dac_code | output | 12 | SAR trial word to the DAC |

## Verification
Two events can fall on the same rising edge. The LSB decision finishes, and on that edge the block can also accept the next start bit. The bench provokes this by holding `din` high across back-to-back conversions, so the first rising edge after each LSB decision carries a 1. It then judges the second conversion's track, strobe, channel and result timing against the same fixed offsets as the first. Ones that arrive during the decision phase must not realign the frame, which would show up as a shifted result on `dout`.

// File: rtl/sar_adc_serial.sv
module sar_adc_serial #(
  parameter int RES = 12
) (
  input  logic           sclk,
  input  logic           cs_n,
  input  logic           din,
  input  logic           cmp_hi,
  output logic           dout,
  output logic           dout_oe,
  output logic           sstrb,
  output logic           sstrb_oe,
  output logic           track,
  output logic [2:0]     ch_pos,
  output logic [2:0]     ch_neg,
  output logic           neg_gnd,
  output logic           bipolar,
  output logic [RES-1:0] dac_code
);
  localparam int LAST = 8 + RES;
  localparam int CW   = $clog2(LAST + 1);
  localparam logic [CW-1:0] C_TRK  = CW'(5);
  localparam logic [CW-1:0] C_HOLD = CW'(8);
  localparam logic [CW-1:0] C_MSB  = CW'(9);
  localparam logic [CW-1:0] C_LAST = CW'(LAST);

  logic [CW-1:0]  cnt;
  logic [6:0]     sr;
  logic           sgl;
  logic [2:0]     code;
  logic           decide;
  logic [RES-1:0] bitm;

  assign decide   = (cnt >= C_MSB) && (cnt <= C_LAST);
  assign bitm     = {{(RES-1){1'b0}}, 1'b1} << (C_LAST - cnt);
  assign dout_oe  = ~cs_n;
  assign sstrb_oe = ~cs_n;
  assign ch_pos   = code;
  assign ch_neg   = {code[2:1], ~code[0]};
  assign neg_gnd  = sgl;

  always_ff @(posedge sclk or posedge cs_n) begin
    if (cs_n) begin
      cnt <= '0;
      sr  <= '0;
    end else if (cnt == '0) begin
      if (din) cnt <= CW'(1);
    end else if (cnt == C_LAST) begin
      cnt <= {{(CW-1){1'b0}}, din};
    end else begin
      cnt <= cnt + CW'(1);
      if (cnt < C_HOLD) sr <= {sr[5:0], din};
    end
  end

  always_ff @(negedge sclk or posedge cs_n) begin
    if (cs_n) begin
      track    <= 1'b0;
      sstrb    <= 1'b0;
      dout     <= 1'b0;
      sgl      <= 1'b0;
      code     <= '0;
      bipolar  <= 1'b0;
      dac_code <= '0;
    end else begin
      sstrb <= (cnt == C_HOLD);
      dout  <= decide & cmp_hi;
      if (cnt == C_TRK) begin
        track <= 1'b1;
        sgl   <= sr[3];
        code  <= sr[2:0];
      end
      if (cnt == C_HOLD) begin
        track    <= 1'b0;
        bipolar  <= ~sr[2];
        dac_code <= {1'b1, {(RES-1){1'b0}}};
      end
      if (decide)
        dac_code <= (dac_code & ~bitm) | (cmp_hi ? bitm : '0) | (bitm >> 1);
    end
  end

  assert_strobe_one_period_R4: assert property (@(negedge sclk) disable iff (cs_n)
    sstrb |=> !sstrb);
  assert_hold_with_strobe_R3: assert property (@(negedge sclk) disable iff (cs_n)
    $fell(track) |-> $rose(sstrb));
  assert_msb_trial_R7: assert property (@(negedge sclk) disable iff (cs_n)
    sstrb |-> (dac_code == {1'b1, {(RES-1){1'b0}}}));
  assert_channel_stable_R5: assert property (@(negedge sclk) disable iff (cs_n)
    (track && !$rose(track)) |-> $stable(ch_pos));
  assert_quiet_strobe_R10: assert property (@(negedge sclk) disable iff (cs_n)
    sstrb |-> !dout);
  assert_no_strobe_in_track_R3: assert property (@(negedge sclk) disable iff (cs_n)
    track |-> !sstrb);
endmodule

// File: tb/sim_sar_adc_serial.sv
`timescale 1ns/1ps
module sim_sar_adc_serial;
  logic sclk = 1'b0, cs_n = 1'b1, din = 1'b0, cmp_hi;
  logic dout, dout_oe, sstrb, sstrb_oe, track, neg_gnd, bipolar;
  logic [2:0] ch_pos, ch_neg;
  logic [11:0] dac_code;
  logic [11:0] analog = '0;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic exp_q[$];

  always #2.5 sclk = ~sclk;
  assign cmp_hi = (analog >= dac_code);

  sar_adc_serial u0 (.sclk, .cs_n, .din, .cmp_hi, .dout, .dout_oe, .sstrb, .sstrb_oe,
                     .track, .ch_pos, .ch_neg, .neg_gnd, .bipolar, .dac_code);

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", r, act, exp, $time);
    end
  endtask

  always begin
    @(posedge sclk); #1;
    if (exp_q.size() > 0) chk("R8 dout", dout, exp_q.pop_front());
  end

  // Starts at negedge+1; lz leading zeros, abort_at>0 drops cs_n before that bit.
  task automatic convert(int lz, bit sgl, logic [2:0] code, bit uni,
                         logic [11:0] a, bit fill, int abort_at);
    logic [7:0] ctl = {1'b1, sgl, code, uni, 2'b00};
    analog = a;
    for (int i = 0; i < lz; i++) begin din = 1'b0; @(negedge sclk); #1; end
    for (int k = 1; k <= 20; k++) begin
      if (k == abort_at) begin
        cs_n = 1'b1;
        @(negedge sclk); #1;
        chk("R2 oe", {dout_oe, sstrb_oe}, 0);
        chk("R2 track", track, 0);
        chk("R2 dac", dac_code, 0);
        din = 1'b1;
        for (int j = 0; j < 3; j++) begin @(negedge sclk); #1; end
        chk("R2 ignored", dac_code, 0);
        cs_n = 1'b0; din = 1'b0;
        @(negedge sclk); #1;
        chk("R2 restart", track, 0);
        return;
      end
      din = (k <= 8) ? ctl[8-k] : fill;
      @(negedge sclk); #1;
      if (k == 4) chk("R3 pre-track", track, 0);
      if (k == 5) begin
        chk("R3 track", track, 1);
        chk("R5 ch_pos", ch_pos, code);
        chk("R5 neg_gnd", neg_gnd, sgl);
        if (!sgl) chk("R5 ch_neg", ch_neg, {code[2:1], ~code[0]});
      end
      if (k == 7) chk("R3 still track", track, 1);
      if (k == 8) begin
        chk("R3 hold", track, 0);
        chk("R4 strobe", sstrb, 1);
        chk("R7 msb trial", dac_code, 12'h800);
        chk("R6 bipolar", bipolar, !uni);
        exp_q.push_back(1'b0);
        for (int b = 11; b >= 0; b--) exp_q.push_back(a[b]);
        exp_q.push_back(1'b0);
        exp_q.push_back(1'b0);
      end
      if (k == 9) chk("R4 strobe end", sstrb, 0);
      if (k == 20) chk("R7 result", dac_code, a);
    end
    din = fill;
  endtask

  initial begin
    din = 1'b1;
    repeat (3) @(negedge sclk);
    #1;
    chk("R2 reset oe", {dout_oe, sstrb_oe}, 0);
    chk("R2 reset state", {track, sstrb, dac_code}, 0);
    cs_n = 1'b0; din = 1'b0;
    convert(0, 1'b1, 3'd3, 1'b1, 12'hA5C, 1'b0, 0);
    convert(3, 1'b0, 3'd5, 1'b0, 12'h001, 1'b0, 0);   // R1 leading zeros, R5 diff
    convert(1, 1'b0, 3'd2, 1'b1, 12'h000, 1'b0, 0);
    convert(0, 1'b1, 3'd7, 1'b1, 12'hFFF, 1'b1, 0);   // R9 back to back, fill high
    convert(0, 1'b1, 3'd7, 1'b1, 12'h7FE, 1'b1, 0);
    convert(0, 1'b1, 3'd7, 1'b1, 12'h800, 1'b0, 0);
    convert(2, 1'b1, 3'd1, 1'b1, 12'h3C3, 1'b0, 7);   // R2 abort
    convert(2, 1'b0, 3'd6, 1'b0, 12'h3C3, 1'b0, 0);
    repeat (20) @(negedge sclk);
    #1;
    chk("R8 pad", dout, 0);
    chk("R8 drained", exp_q.size(), 0);
    cs_n = 1'b1;
    @(negedge sclk); #1;
    chk("R2 release", {dout_oe, sstrb_oe}, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
      $finish;
    end
  end
endmodule